// File: doc/BRIEF.md
# Queue Depth Threshold Bucket Tracker

This block keeps an occupancy count for each of a set of event queues. It sorts each count into one of four fullness bands, measured against a threshold that is programmed per queue. An enqueue strobe and a dequeue strobe, each with a queue index, move the counts. The band of the queue being dequeued is presented in the same cycle, so it can be attached to the outgoing event. A second lookup port returns the band of any queue, for monitoring.

Thresholds are written through one port that can address a single queue, an inclusive span of queue indices or every queue at once. For every queue, the block also keeps a saturating count of how many dequeues took place in each band. A combinational read port returns these counts. The queue storage itself lies outside the block.

Top module: `qdb_bucket_tracker`

## Requirements
- R1: After reset every queue has depth zero, every threshold equals the parameter DEF_THR, and every band statistic is zero.
- R2: A queue's band is 0 when 4*depth <= 2*threshold, 1 when 2*threshold < 4*depth <= 3*threshold, 2 when 3*threshold < 4*depth <= 4*threshold, and 3 when depth > threshold. A threshold of zero therefore gives band 0 at depth 0 and band 3 at any other depth.
- R3: An enqueue adds one to the addressed queue's depth and a dequeue subtracts one. Enqueue and dequeue to the same queue in the same cycle leave that depth unchanged, and enqueue and dequeue to different queues in the same cycle both take effect.
- R4: A dequeue from a queue of depth zero leaves its depth at zero.
- R5: An enqueue to a queue whose depth is 2^DEPTH_W-1 leaves the depth at that value.
- R6: A threshold write with thr_mode 0 sets only the queue at index thr_lo.
- R7: A threshold write with thr_mode 1 sets every queue whose index i satisfies thr_lo <= i <= thr_hi. If thr_lo > thr_hi, no queue changes.
- R8: A threshold write with thr_mode 2 sets every queue. thr_mode 3 writes nothing.
- R9: While deq_valid is high, deq_bucket gives the band of deq_qid computed from its depth and threshold before that cycle's update.
- R10: Each dequeue adds one to the statistic for (deq_qid, deq_bucket). The statistic saturates at 2^STAT_W-1.
- R11: look_bucket gives the current band of look_qid, and stat_count gives the statistic selected by stat_qid and stat_bucket, both combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Enqueue strobe |
| enq_qid | input | QID_W | Queue index of the enqueue |
| deq_valid | input | 1 | Dequeue strobe |
| deq_qid | input | QID_W | Queue index of the dequeue |
| deq_bucket | output | 2 | Band of deq_qid, attached to the dequeued event |
| thr_wr | input | 1 | Threshold write strobe |
| thr_mode | input | 2 | 0 single, 1 span, 2 all, 3 no write |
| thr_lo | input | QID_W | Single target, or lower bound of the span |
| thr_hi | input | QID_W | Upper bound of the span |
| thr_value | input | THR_W | Threshold value to write |
| look_qid | input | QID_W | Queue to inspect |
| look_bucket | output | 2 | Current band of look_qid |
| stat_qid | input | QID_W | Queue whose statistic is read |
| stat_bucket | input | 2 | Band whose statistic is read |
| stat_count | output | STAT_W | Selected dequeue-per-band count |

## Verification
A depth counter that wraps instead of holding at zero or at its ceiling cannot be seen directly at the ports. It shows up one cycle later, when the band of that queue jumps to a value that the expected depth cannot produce. A span decode with the wrong bounds shows up as a wrong band on a neighbouring queue, provided every queue holds a depth at which each threshold gives a distinct band. A wrong band on a dequeue is recorded in the wrong statistic at the next edge. It then stays visible through the statistics read port until reset.

// File: rtl/qdb_pkg.sv
// Package: shared types and the band classification function for the
// queue depth bucket tracker. Assumes depth and threshold fit in 32 bits.
package qdb_pkg;

    typedef logic [1:0] band_t;

    typedef enum logic [1:0] {
        THR_ONE  = 2'd0,
        THR_SPAN = 2'd1,
        THR_ALL  = 2'd2,
        THR_NONE = 2'd3
    } thr_mode_e;

    // Band of a depth against a threshold, using only shifts and adds.
    function automatic band_t band_of(input logic [31:0] d, input logic [31:0] t);
        logic [33:0] d4;
        logic [33:0] t2;
        logic [33:0] t3;
        logic [33:0] t4;
        d4 = {d, 2'b00};
        t2 = {1'b0, t, 1'b0};
        t3 = t2 + {2'b00, t};
        t4 = {t, 2'b00};
        if (d4 <= t2)      return 2'd0;
        else if (d4 <= t3) return 2'd1;
        else if (d4 <= t4) return 2'd2;
        else               return 2'd3;
    endfunction

endpackage

// File: rtl/qdb_depth_bank.sv
// Module: per-queue occupancy counters.
// Assumes one enqueue and one dequeue strobe per cycle at most; counters
// hold at zero and at their ceiling instead of wrapping.
module qdb_depth_bank #(
    parameter int NUM_Q   = 8,
    parameter int DEPTH_W = 8,
    parameter int QID_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enq_valid,
    input  logic [QID_W-1:0]           enq_qid,
    input  logic                       deq_valid,
    input  logic [QID_W-1:0]           deq_qid,
    output logic [NUM_Q*DEPTH_W-1:0]   depth_flat
);

    localparam logic [DEPTH_W-1:0] DEPTH_MAX = {DEPTH_W{1'b1}};

    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
        localparam logic [QID_W-1:0] IDX = QID_W'(i);
        logic               inc;
        logic               dec;
        logic [DEPTH_W-1:0] cnt_q;

        assign inc = enq_valid && (enq_qid == IDX);
        assign dec = deq_valid && (deq_qid == IDX);

        // Move the count by the net of enqueue and dequeue, clamped.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (inc && !dec && cnt_q != DEPTH_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (dec && !inc && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        assign depth_flat[i*DEPTH_W +: DEPTH_W] = cnt_q;
    end

endmodule

// File: rtl/qdb_thr_bank.sv
// Module: per-queue threshold registers with single, span and broadcast
// writes. Assumes span bounds are inclusive; an inverted span hits nothing.
module qdb_thr_bank #(
    parameter int NUM_Q   = 8,
    parameter int THR_W   = 8,
    parameter int QID_W   = 3,
    parameter int DEF_THR = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     thr_wr,
    input  logic [1:0]               thr_mode,
    input  logic [QID_W-1:0]         thr_lo,
    input  logic [QID_W-1:0]         thr_hi,
    input  logic [THR_W-1:0]         thr_value,
    output logic [NUM_Q*THR_W-1:0]   thr_flat
);
    import qdb_pkg::*;

    localparam logic [THR_W-1:0] THR_RST = THR_W'(DEF_THR);

    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
        localparam logic [QID_W-1:0] IDX = QID_W'(i);
        logic             hit;
        logic [THR_W-1:0] thr_q;

        // Decide whether this queue is addressed by the current write.
        always_comb begin
            unique case (thr_mode_e'(thr_mode))
                THR_ONE:  hit = (thr_lo == IDX);
                THR_SPAN: hit = (thr_lo <= IDX) && (IDX <= thr_hi);
                THR_ALL:  hit = 1'b1;
                default:  hit = 1'b0;
            endcase
        end

        // Load the new threshold when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                thr_q <= THR_RST;
            end else if (thr_wr && hit) begin
                thr_q <= thr_value;
            end
        end

        assign thr_flat[i*THR_W +: THR_W] = thr_q;
    end

endmodule

// File: rtl/qdb_band_classify.sv
// Module: selects one queue's depth and threshold and returns its band.
// Purely combinational; assumes qid < NUM_Q.
module qdb_band_classify #(
    parameter int NUM_Q   = 8,
    parameter int DEPTH_W = 8,
    parameter int THR_W   = 8,
    parameter int QID_W   = 3
) (
    input  logic [NUM_Q*DEPTH_W-1:0] depth_flat,
    input  logic [NUM_Q*THR_W-1:0]   thr_flat,
    input  logic [QID_W-1:0]         qid,
    output logic [1:0]               band
);
    import qdb_pkg::*;

    logic [DEPTH_W-1:0] d_sel;
    logic [THR_W-1:0]   t_sel;

    // Pick the addressed queue and classify it.
    always_comb begin
        d_sel = depth_flat[qid*DEPTH_W +: DEPTH_W];
        t_sel = thr_flat[qid*THR_W +: THR_W];
        band  = band_of(32'(d_sel), 32'(t_sel));
    end

endmodule

// File: rtl/qdb_stat_bank.sv
// Module: saturating dequeue counters per queue and per band, with a
// combinational read mux. Assumes deq_band is the band at dequeue time.
module qdb_stat_bank #(
    parameter int NUM_Q  = 8,
    parameter int STAT_W = 16,
    parameter int QID_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deq_valid,
    input  logic [QID_W-1:0]  deq_qid,
    input  logic [1:0]        deq_band,
    input  logic [QID_W-1:0]  rd_qid,
    input  logic [1:0]        rd_band,
    output logic [STAT_W-1:0] rd_count
);

    localparam int NUM_BANDS = 4;
    localparam int NUM_CNT   = NUM_Q * NUM_BANDS;
    localparam logic [STAT_W-1:0] STAT_MAX = {STAT_W{1'b1}};

    logic [NUM_CNT*STAT_W-1:0] cnt_flat;

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        for (genvar b = 0; b < NUM_BANDS; b++) begin : g_b
            localparam logic [QID_W-1:0] QIDX = QID_W'(q);
            localparam logic [1:0]       BIDX = 2'(b);
            logic [STAT_W-1:0] cnt_q;

            // Count dequeues in this band for this queue, holding at max.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (deq_valid && deq_qid == QIDX && deq_band == BIDX
                             && cnt_q != STAT_MAX) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign cnt_flat[(q*NUM_BANDS+b)*STAT_W +: STAT_W] = cnt_q;
        end
    end

    // Return the selected counter.
    always_comb begin
        rd_count = cnt_flat[({rd_qid, rd_band})*STAT_W +: STAT_W];
    end

endmodule

// File: rtl/qdb_bucket_tracker.sv
// Module: top of the queue depth bucket tracker. Tracks occupancy per
// queue, classifies it against a per-queue threshold, tags dequeues with
// the band and keeps per-band dequeue statistics.
// Assumes NUM_Q is a power of two and at least 2.
module qdb_bucket_tracker #(
    parameter int NUM_Q   = 8,
    parameter int DEPTH_W = 8,
    parameter int THR_W   = 8,
    parameter int STAT_W  = 16,
    parameter int DEF_THR = 8,
    localparam int QID_W  = $clog2(NUM_Q)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic [QID_W-1:0]  enq_qid,
    input  logic              deq_valid,
    input  logic [QID_W-1:0]  deq_qid,
    output logic [1:0]        deq_bucket,
    input  logic              thr_wr,
    input  logic [1:0]        thr_mode,
    input  logic [QID_W-1:0]  thr_lo,
    input  logic [QID_W-1:0]  thr_hi,
    input  logic [THR_W-1:0]  thr_value,
    input  logic [QID_W-1:0]  look_qid,
    output logic [1:0]        look_bucket,
    input  logic [QID_W-1:0]  stat_qid,
    input  logic [1:0]        stat_bucket,
    output logic [STAT_W-1:0] stat_count
);

    logic [NUM_Q*DEPTH_W-1:0] depth_flat;
    logic [NUM_Q*THR_W-1:0]   thr_flat;

    qdb_depth_bank #(.NUM_Q(NUM_Q), .DEPTH_W(DEPTH_W), .QID_W(QID_W)) u_depth (
        .clk        (clk),
        .rst_n      (rst_n),
        .enq_valid  (enq_valid),
        .enq_qid    (enq_qid),
        .deq_valid  (deq_valid),
        .deq_qid    (deq_qid),
        .depth_flat (depth_flat)
    );

    qdb_thr_bank #(.NUM_Q(NUM_Q), .THR_W(THR_W), .QID_W(QID_W), .DEF_THR(DEF_THR)) u_thr (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_wr    (thr_wr),
        .thr_mode  (thr_mode),
        .thr_lo    (thr_lo),
        .thr_hi    (thr_hi),
        .thr_value (thr_value),
        .thr_flat  (thr_flat)
    );

    qdb_band_classify #(.NUM_Q(NUM_Q), .DEPTH_W(DEPTH_W), .THR_W(THR_W), .QID_W(QID_W)) u_deq_cls (
        .depth_flat (depth_flat),
        .thr_flat   (thr_flat),
        .qid        (deq_qid),
        .band       (deq_bucket)
    );

    qdb_band_classify #(.NUM_Q(NUM_Q), .DEPTH_W(DEPTH_W), .THR_W(THR_W), .QID_W(QID_W)) u_look_cls (
        .depth_flat (depth_flat),
        .thr_flat   (thr_flat),
        .qid        (look_qid),
        .band       (look_bucket)
    );

    qdb_stat_bank #(.NUM_Q(NUM_Q), .STAT_W(STAT_W), .QID_W(QID_W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .deq_valid (deq_valid),
        .deq_qid   (deq_qid),
        .deq_band  (deq_bucket),
        .rd_qid    (stat_qid),
        .rd_band   (stat_bucket),
        .rd_count  (stat_count)
    );

endmodule

// File: rtl/qdb_bucket_tracker_chk.sv
// Module: assertion checker bound to the bucket tracker. Observes the
// ports and the depth and threshold vectors; drives nothing.
module qdb_bucket_tracker_chk #(
    parameter int NUM_Q   = 8,
    parameter int DEPTH_W = 8,
    parameter int THR_W   = 8,
    parameter int QID_W   = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     enq_valid,
    input logic [QID_W-1:0]         enq_qid,
    input logic                     deq_valid,
    input logic [QID_W-1:0]         deq_qid,
    input logic [1:0]               deq_bucket,
    input logic [QID_W-1:0]         look_qid,
    input logic [1:0]               look_bucket,
    input logic [NUM_Q*DEPTH_W-1:0] depth_flat,
    input logic [NUM_Q*THR_W-1:0]   thr_flat
);

    localparam logic [DEPTH_W-1:0] DEPTH_MAX = {DEPTH_W{1'b1}};

    logic [DEPTH_W-1:0] d_enq, d_deq, d_look;
    logic [THR_W-1:0]   t_look;
    logic [QID_W-1:0]   q_enq_r, q_deq_r;
    logic [DEPTH_W-1:0] d_enq_r;
    logic               same_r, empty_r, full_r;

    // Current depth and threshold of the addressed queues.
    always_comb begin
        d_enq  = depth_flat[enq_qid*DEPTH_W +: DEPTH_W];
        d_deq  = depth_flat[deq_qid*DEPTH_W +: DEPTH_W];
        d_look = depth_flat[look_qid*DEPTH_W +: DEPTH_W];
        t_look = thr_flat[look_qid*THR_W +: THR_W];
    end

    // Remember last cycle's conditions for next-cycle checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            same_r  <= 1'b0;
            empty_r <= 1'b0;
            full_r  <= 1'b0;
            q_enq_r <= '0;
            q_deq_r <= '0;
            d_enq_r <= '0;
        end else begin
            same_r  <= enq_valid && deq_valid && enq_qid == deq_qid;
            empty_r <= deq_valid && d_deq == '0 && !(enq_valid && enq_qid == deq_qid);
            full_r  <= enq_valid && d_enq == DEPTH_MAX && !(deq_valid && enq_qid == deq_qid);
            q_enq_r <= enq_qid;
            q_deq_r <= deq_qid;
            d_enq_r <= d_enq;
        end
    end

    // R3
    same_q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        same_r |-> depth_flat[q_enq_r*DEPTH_W +: DEPTH_W] == d_enq_r);

    // R4
    empty_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_r |-> depth_flat[q_deq_r*DEPTH_W +: DEPTH_W] == '0);

    // R5
    full_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_r |-> depth_flat[q_enq_r*DEPTH_W +: DEPTH_W] == DEPTH_MAX);

    // R2
    over_thr_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (look_bucket == 2'd3) == (32'(d_look) > 32'(t_look)));

    // R9
    deq_look_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && deq_qid == look_qid) |-> deq_bucket == look_bucket);

endmodule

bind qdb_bucket_tracker qdb_bucket_tracker_chk #(
    .NUM_Q(NUM_Q), .DEPTH_W(DEPTH_W), .THR_W(THR_W), .QID_W(QID_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enq_valid   (enq_valid),
    .enq_qid     (enq_qid),
    .deq_valid   (deq_valid),
    .deq_qid     (deq_qid),
    .deq_bucket  (deq_bucket),
    .look_qid    (look_qid),
    .look_bucket (look_bucket),
    .depth_flat  (depth_flat),
    .thr_flat    (thr_flat)
);

// File: tb/qdb_bucket_tracker_tb.sv
// Bench: small configuration, band sweeps over every depth for a set of
// thresholds, threshold write modes, and statistics with saturation.
module qdb_bucket_tracker_tb;

    localparam int NQ  = 8;
    localparam int DW  = 6;
    localparam int TW  = 6;
    localparam int SW  = 4;
    localparam int QW  = 3;
    localparam int DEF = 8;
    localparam int DMAX = (1 << DW) - 1;
    localparam int SMAX = (1 << SW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          enq_valid, deq_valid, thr_wr;
    logic [QW-1:0] enq_qid, deq_qid, thr_lo, thr_hi, look_qid, stat_qid;
    logic [1:0]    thr_mode, stat_bucket, deq_bucket, look_bucket;
    logic [TW-1:0] thr_value;
    logic [SW-1:0] stat_count;

    always #4 clk = ~clk;

    qdb_bucket_tracker #(.NUM_Q(NQ), .DEPTH_W(DW), .THR_W(TW), .STAT_W(SW), .DEF_THR(DEF)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_qid(enq_qid),
        .deq_valid(deq_valid), .deq_qid(deq_qid), .deq_bucket(deq_bucket),
        .thr_wr(thr_wr), .thr_mode(thr_mode), .thr_lo(thr_lo), .thr_hi(thr_hi),
        .thr_value(thr_value),
        .look_qid(look_qid), .look_bucket(look_bucket),
        .stat_qid(stat_qid), .stat_bucket(stat_bucket), .stat_count(stat_count)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int depth_m [NQ];
    int thr_m   [NQ];
    int stat_m  [NQ][4];

    // Expected band from percentage bands of the threshold.
    function automatic int exp_band(int d, int t);
        if (d * 100 <= t * 50)      return 0;
        else if (d * 100 <= t * 75) return 1;
        else if (d <= t)            return 2;
        else                        return 3;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock of stimulus; updates the model after the edge.
    task automatic step(bit e, int eq, bit d, int dq, bit w, int mode,
                        int lo, int hi, int val, string tag);
        @(negedge clk);
        enq_valid = e; enq_qid = QW'(eq);
        deq_valid = d; deq_qid = QW'(dq);
        thr_wr = w; thr_mode = 2'(mode); thr_lo = QW'(lo); thr_hi = QW'(hi);
        thr_value = TW'(val);
        #1;
        if (d) chk({tag, " deq_bucket"}, int'(deq_bucket), exp_band(depth_m[dq], thr_m[dq]));
        @(posedge clk);
        #1;
        if (d) begin
            int b = exp_band(depth_m[dq], thr_m[dq]);
            if (stat_m[dq][b] < SMAX) stat_m[dq][b]++;
        end
        if (!(e && d && eq == dq)) begin
            if (e && depth_m[eq] < DMAX) depth_m[eq]++;
            if (d && depth_m[dq] > 0)    depth_m[dq]--;
        end
        if (w) begin
            for (int q = 0; q < NQ; q++) begin
                if ((mode == 0 && q == lo) || (mode == 1 && q >= lo && q <= hi) || mode == 2)
                    thr_m[q] = val;
            end
        end
        enq_valid = 0; deq_valid = 0; thr_wr = 0;
    endtask

    task automatic look_one(string tag, int q);
        look_qid = QW'(q);
        #1;
        chk(tag, int'(look_bucket), exp_band(depth_m[q], thr_m[q]));
    endtask

    task automatic check_all(string tag);
        for (int q = 0; q < NQ; q++) look_one(tag, q);
    endtask

    task automatic check_stats(string tag);
        for (int q = 0; q < NQ; q++) begin
            for (int b = 0; b < 4; b++) begin
                stat_qid = QW'(q); stat_bucket = 2'(b);
                #1;
                chk(tag, int'(stat_count), stat_m[q][b]);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int sweep [8] = '{0, 1, 4, 7, 8, 13, 20, 62};
        enq_valid = 0; deq_valid = 0; thr_wr = 0;
        enq_qid = 0; deq_qid = 0; thr_mode = 0; thr_lo = 0; thr_hi = 0;
        thr_value = 0; look_qid = 0; stat_qid = 0; stat_bucket = 0;
        for (int q = 0; q < NQ; q++) begin
            depth_m[q] = 0; thr_m[q] = DEF;
            for (int b = 0; b < 4; b++) stat_m[q][b] = 0;
        end
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state, including the default threshold on q1
        check_all("R1 reset band");
        check_stats("R1 reset stats");
        for (int k = 0; k < 5; k++) step(1, 1, 0, 0, 0, 0, 0, 0, 0, "R1");
        look_one("R1 default threshold", 1);

        // R8 and R2/R5/R9/R4 sweep over q0 for several thresholds
        foreach (sweep[s]) begin
            step(0, 0, 0, 0, 1, 2, 0, 0, sweep[s], "R8");
            check_all("R8 broadcast");
            for (int k = 0; k < DMAX + 2; k++) begin
                step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
                look_one(k >= DMAX ? "R5 ceiling" : "R2 band", 0);
            end
            for (int k = 0; k < DMAX; k++) begin
                step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R9");
                look_one("R2 band down", 0);
            end
            step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R4");
            look_one("R4 floor", 0);
            step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
            look_one("R4 after floor", 0);
            step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R9");
        end
        check_stats("R10 saturating stats");

        // R3: simultaneous same queue, then different queues
        step(0, 0, 0, 0, 1, 2, 0, 0, 4, "R3");
        step(1, 2, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(1, 2, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(1, 2, 1, 2, 0, 0, 0, 0, 0, "R3");
        look_one("R3 same queue", 2);
        step(1, 3, 1, 2, 0, 0, 0, 0, 0, "R3");
        check_all("R3 different queues");

        // Bring every queue to depth 5 so each threshold band differs
        for (int q = 0; q < NQ; q++) begin
            while (depth_m[q] < 5) step(1, q, 0, 0, 0, 0, 0, 0, 0, "R3");
            while (depth_m[q] > 5) step(0, 0, 1, q, 0, 0, 0, 0, 0, "R3");
        end
        step(0, 0, 0, 0, 1, 2, 0, 0, 10, "R8");
        check_all("R8 all");
        step(0, 0, 0, 0, 1, 0, 3, 6, 4, "R6");
        check_all("R6 single");
        step(0, 0, 0, 0, 1, 1, 2, 5, 7, "R7");
        check_all("R7 span");
        step(0, 0, 0, 0, 1, 1, 6, 1, 5, "R7");
        check_all("R7 inverted span");
        step(0, 0, 0, 0, 1, 1, 0, 7, 5, "R7");
        check_all("R7 full span");
        step(0, 0, 0, 0, 1, 3, 0, 7, 20, "R8");
        check_all("R8 mode 3 ignored");

        // R9/R10/R11: dequeues in several bands across queues
        for (int q = 0; q < NQ; q++) begin
            step(0, 0, 0, 0, 1, 0, q, 0, q + 3, "R10");
            step(0, 0, 1, q, 0, 0, 0, 0, 0, "R9");
            step(0, 0, 1, q, 0, 0, 0, 0, 0, "R9");
        end
        check_stats("R11 stat read");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule